// File: doc/BRIEF.md
# Sixteen-line parallel I/O port with dual interrupts

This block is a 16-line general-purpose I/O port controlled through a small register port. A direction bit per line decides whether the line drives its pad from a data register or acts as an input. Input lines pass through a two-flop synchroniser. Each input can then raise a status flag in one of two ways. In level mode the flag simply mirrors the qualified input. In edge mode the flag captures a rising edge of the qualified input and holds it until software clears it by writing a one.

A polarity bit per line inverts the input before detection, so edge mode can also catch falling pad edges. Each line is routed by a select bit to one of two interrupt outputs, and an enable bit gates it. The interrupt outputs combine the flags of all enabled lines mapped to them.

A separate wake-up output is formed without any register from the raw pads. It covers enabled input lines, with polarity applied, and so works while the clock is stopped.

Register map, with a 3-bit address: 0 drive data, 1 direction (1 = output), 2 sense (1 = edge, 0 = level), 3 polarity (1 = invert), 4 interrupt enable, 5 interrupt select (0 = first output, 1 = second), 6 flags (read; write one to clear), 7 synchronised pad state (read only).

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset, every line is an input (`pad_oe` = 0), both interrupt outputs are low, and every register at addresses 0 to 6 reads 0.
- R2: A line whose direction bit is 1 drives its bit of the drive register on `pad_out` with its `pad_oe` bit high. Address 7 returns `pad_in` delayed by exactly two clock edges.
- R3: In level mode (sense bit 0), the flag bit of an input line equals its synchronised pad value XOR its polarity bit. The flag rises and falls with the input and does not latch.
- R4: In edge mode (sense bit 1), a 0-to-1 change of the synchronised pad value XOR polarity on an input line sets its flag. The flag then stays set after the input returns low.
- R5: Writing address 6 clears each edge-mode flag whose written bit is 1. Bits written 0 are unchanged, and level-mode flags are not affected by the write.
- R6: With the polarity bit set, an edge-mode line flags on a falling pad edge and ignores a rising pad edge.
- R7: A line whose direction bit is 1 never shows a flag, in either mode, whatever its pad does.
- R8: `irq_a` is high when some flag is set on a line with enable 1 and select 0. `irq_b` is high when some flag is set on a line with enable 1 and select 1. Disabled lines raise neither.
- R9: `wake` is high exactly when some line has direction 0, enable 1 and (raw `pad_in` XOR polarity) = 1. It follows `pad_in` with no clock edge in its path.
- R10: Addresses 0 to 5 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| pad_in | input | 16 | Pad input levels (asynchronous) |
| pad_out | output | 16 | Pad drive values |
| pad_oe | output | 16 | Pad output enables |
| irq_a | output | 1 | First interrupt output |
| irq_b | output | 1 | Second interrupt output |
| wake | output | 1 | Unregistered wake-up request |

## Verification
On every cycle the assertions check several properties. Each synchroniser stage copies the previous one. An edge flag only appears after a detected qualified rise, and it only disappears through a clear write, a mode change or a direction change. Output lines never carry a flag, and interrupts never fire without an enabled flag. The register values only move on a write to their own address, and wake stays low when no input line is enabled.

Some behaviour can only be shown by the bench's scenarios. These include the routing of flags to the two outputs over many configurations, and the two-edge latency of the pad readback. They also include the inverted-polarity edge behaviour, the one-only effect of the clear write, and the response of wake to a pad change before any clock edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int NLINES      = 16;
    localparam int ADDR_W      = 3;
    localparam int SYNC_STAGES = 2;
    localparam int NIRQ        = 2;

    typedef logic [NLINES-1:0] lines_t;

    typedef enum logic [ADDR_W-1:0] {
        A_DRIVE = 3'd0,
        A_DIR   = 3'd1,
        A_SENSE = 3'd2,
        A_POL   = 3'd3,
        A_EN    = 3'd4,
        A_SEL   = 3'd5,
        A_FLAG  = 3'd6,
        A_PIN   = 3'd7
    } reg_addr_e;

    typedef struct packed {
        lines_t drive;
        lines_t dir;
        lines_t sense;
        lines_t pol;
        lines_t en;
        lines_t sel;
    } port_cfg_t;

    // Lines that belong to interrupt output idx: select 0 -> output 0, select 1 -> output 1
    function automatic lines_t route_mask(lines_t sel, int idx);
        return (idx == 0) ? ~sel : sel;
    endfunction

    // Input qualified by polarity, masked to lines that are inputs
    function automatic lines_t qualify(lines_t raw, lines_t pol, lines_t dir);
        return (raw ^ pol) & ~dir;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] st [STAGES];
    logic             past_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) st[k] <= '0;
            past_valid <= 1'b0;
        end else begin
            st[0] <= d;
            for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
            past_valid <= 1'b1;
        end
    end

    assign q = st[STAGES-1];

    generate
        for (genvar k = 1; k < STAGES; k++) begin : g_chk
            // R2
            sync_shift_chk: assert property (@(posedge clk) disable iff (rst)
                past_valid |-> (st[k] == $past(st[k-1])))
                else $error("synchroniser stage %0d did not shift", k);
        end
    endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  lines_t            wdata,
    input  lines_t            flags,
    input  lines_t            pins,
    output port_cfg_t         cfg,
    output lines_t            clr,
    output lines_t            rdata
);
    reg_addr_e a;
    assign a = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr) begin
            case (a)
                A_DRIVE: cfg.drive <= wdata;
                A_DIR:   cfg.dir   <= wdata;
                A_SENSE: cfg.sense <= wdata;
                A_POL:   cfg.pol   <= wdata;
                A_EN:    cfg.en    <= wdata;
                A_SEL:   cfg.sel   <= wdata;
                default: ;
            endcase
        end
    end

    always_comb clr = (wr && (a == A_FLAG)) ? wdata : '0;

    always_comb begin
        case (a)
            A_DRIVE: rdata = cfg.drive;
            A_DIR:   rdata = cfg.dir;
            A_SENSE: rdata = cfg.sense;
            A_POL:   rdata = cfg.pol;
            A_EN:    rdata = cfg.en;
            A_SEL:   rdata = cfg.sel;
            A_FLAG:  rdata = flags;
            default: rdata = pins;
        endcase
    end

    // R10
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr && a == A_DIR) |=> $stable(cfg.dir))
        else $error("direction changed without a write");
    // R10
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr && a == A_EN) |=> $stable(cfg.en))
        else $error("enable changed without a write");
endmodule

// File: rtl/gpio_capture.sv
module gpio_capture
    import gpio_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  lines_t pins,
    input  lines_t dir,
    input  lines_t sense,
    input  lines_t pol,
    input  lines_t clr,
    output lines_t flags
);
    lines_t qual, prev, rise, edge_q, level_v;

    assign qual    = pins ^ pol;
    assign rise    = qual & ~prev & ~dir;
    assign level_v = qualify(pins, pol, dir);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= '0;
            edge_q <= '0;
        end else begin
            prev   <= qual;
            // set wins over a clear in the same cycle
            edge_q <= ((edge_q & ~clr) | rise) & sense & ~dir;
        end
    end

    generate
        for (genvar i = 0; i < NLINES; i++) begin : g_line
            assign flags[i] = sense[i] ? edge_q[i] : level_v[i];
        end
    endgenerate

    // R4
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(edge_q) & ~edge_q & ~$past(clr | ~sense | dir)) == '0))
        else $error("edge flag dropped without a clear");
    // R4
    edge_set_chk: assert property (@(posedge clk) disable iff (rst)
        ((~$past(edge_q) & edge_q & ~$past(rise)) == '0))
        else $error("edge flag set without a rise");
    // R7
    out_line_chk: assert property (@(posedge clk) disable iff (rst)
        ((flags & dir) == '0))
        else $error("output line carries a flag");
endmodule

// File: rtl/gpio_route.sv
module gpio_route
    import gpio_pkg::*;
(
    input  lines_t            flags,
    input  lines_t            en,
    input  lines_t            sel,
    input  lines_t            raw,
    input  lines_t            pol,
    input  lines_t            dir,
    output logic [NIRQ-1:0]   irq,
    output logic              wake
);
    generate
        for (genvar g = 0; g < NIRQ; g++) begin : g_irq
            assign irq[g] = |(flags & en & route_mask(sel, g));
        end
    endgenerate

    // no register anywhere on this path
    assign wake = |(qualify(raw, pol, dir) & en);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NLINES-1:0] reg_wdata,
    output logic [NLINES-1:0] reg_rdata,
    input  logic [NLINES-1:0] pad_in,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] pad_oe,
    output logic              irq_a,
    output logic              irq_b,
    output logic              wake
);
    port_cfg_t        cfg;
    lines_t           pins, flags, clr;
    logic [NIRQ-1:0]  irq;

    gpio_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(pins)
    );

    gpio_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .flags(flags), .pins(pins), .cfg(cfg), .clr(clr), .rdata(reg_rdata)
    );

    gpio_capture u_cap (
        .clk(clk), .rst(rst), .pins(pins), .dir(cfg.dir), .sense(cfg.sense),
        .pol(cfg.pol), .clr(clr), .flags(flags)
    );

    gpio_route u_route (
        .flags(flags), .en(cfg.en), .sel(cfg.sel), .raw(pad_in),
        .pol(cfg.pol), .dir(cfg.dir), .irq(irq), .wake(wake)
    );

    assign pad_out = cfg.drive;
    assign pad_oe  = cfg.dir;
    assign irq_a   = irq[0];
    assign irq_b   = irq[1];

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        (irq != '0) |-> ((flags & cfg.en) != '0))
        else $error("interrupt without an enabled flag");
    // R9
    wake_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ((cfg.en & ~cfg.dir) == '0) |-> !wake)
        else $error("wake with no enabled input");
endmodule

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic [15:0] pad_in = 16'h0;
    logic [15:0] pad_out, pad_oe;
    logic        irq_a, irq_b, wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    gpio_port i_gpio_port (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_a(irq_a), .irq_b(irq_b),
        .wake(wake)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic [15:0] dir, pol, en, sel, pins, flags;
        logic        ia, ib, wk;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 16'h00A5, 16'h00A5, 1'b1, 1'b0, 1'b1},
        '{16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h00FF, 16'hFF00, 1'b0, 1'b1, 1'b1},
        '{16'hFF00, 16'h0000, 16'hFFFF, 16'h0F0F, 16'hFFFF, 16'h00FF, 1'b1, 1'b1, 1'b1},
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h1234, 16'h1234, 1'b0, 1'b0, 1'b0},
        '{16'h0000, 16'h0000, 16'h0001, 16'h0001, 16'hFFFE, 16'hFFFE, 1'b0, 1'b0, 1'b0},
        '{16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic set_pads(logic [15:0] v);
        @(negedge clk);
        pad_in = v;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 oe", pad_oe, 16'h0000);
        check("R1 irq", {14'h0, irq_a, irq_b}, 16'h0);
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            check("R1 reg", v, 16'h0000);
        end

        // R10 readback
        for (int a = 0; a < 6; a++) begin
            wr(3'(a), 16'h1111 * 16'(a + 1));
            rd(3'(a), v);
            check("R10 readback", v, 16'h1111 * 16'(a + 1));
        end
        for (int a = 0; a < 6; a++) wr(3'(a), 16'h0000);

        // level-mode vector table (R3, R8, R9, R7)
        foreach (VECS[i]) begin
            wr(3'd1, VECS[i].dir);
            wr(3'd3, VECS[i].pol);
            wr(3'd4, VECS[i].en);
            wr(3'd5, VECS[i].sel);
            set_pads(VECS[i].pins);
            settle();
            rd(3'd6, v);
            check("R3 level flags", v, VECS[i].flags);
            check("R8 irq_a", {15'h0, irq_a}, {15'h0, VECS[i].ia});
            check("R8 irq_b", {15'h0, irq_b}, {15'h0, VECS[i].ib});
            check("R9 wake", {15'h0, wake}, {15'h0, VECS[i].wk});
        end

        // R2 drive and two-edge pad readback
        wr(3'd1, 16'h00FF);
        wr(3'd0, 16'hA55A);
        check("R2 pad_out", pad_out, 16'hA55A);
        check("R2 pad_oe", pad_oe, 16'h00FF);
        set_pads(16'h0000);
        settle();
        @(negedge clk);
        reg_addr = 3'd7;
        pad_in = 16'h3C3C;
        @(negedge clk); #0.5;
        check("R2 pin after one edge", reg_rdata, 16'h0000);
        @(negedge clk); #0.5;
        check("R2 pin after two edges", reg_rdata, 16'h3C3C);

        // R5 clear write leaves level flags alone
        wr(3'd1, 16'h0000);
        wr(3'd3, 16'h0000);
        set_pads(16'h00F0);
        settle();
        wr(3'd6, 16'hFFFF);
        rd(3'd6, v);
        check("R5 level untouched", v, 16'h00F0);

        // R4 edge capture and hold on line 0
        wr(3'd4, 16'h0001);
        wr(3'd5, 16'h0000);
        set_pads(16'h0000);
        settle();
        wr(3'd2, 16'h0001);
        wr(3'd6, 16'hFFFF);
        rd(3'd6, v);
        check("R4 edge idle", v, 16'h0000);
        set_pads(16'h0001);
        settle();
        rd(3'd6, v);
        check("R4 edge set", v, 16'h0001);
        check("R8 edge irq_a", {15'h0, irq_a}, 16'h1);
        set_pads(16'h0000);
        settle();
        rd(3'd6, v);
        check("R4 edge held", v, 16'h0001);

        // R5 write-one-to-clear
        wr(3'd6, 16'hFFFE);
        rd(3'd6, v);
        check("R5 zero bit keeps flag", v, 16'h0001);
        wr(3'd6, 16'h0001);
        rd(3'd6, v);
        check("R5 one bit clears", v, 16'h0000);
        check("R5 irq_a low", {15'h0, irq_a}, 16'h0);

        // R6 inverted polarity edge
        wr(3'd3, 16'h0001);
        settle();
        wr(3'd6, 16'h0001);
        set_pads(16'h0001);
        settle();
        rd(3'd6, v);
        check("R6 rising pad ignored", v, 16'h0000);
        set_pads(16'h0000);
        settle();
        rd(3'd6, v);
        check("R6 falling pad flags", v, 16'h0001);
        wr(3'd3, 16'h0000);
        wr(3'd6, 16'h0001);

        // R7 output line in edge mode
        wr(3'd1, 16'h0001);
        set_pads(16'h0001);
        settle();
        set_pads(16'h0000);
        settle();
        set_pads(16'h0001);
        settle();
        rd(3'd6, v);
        check("R7 output line no flag", v, 16'h0000);

        // R9 wake follows pads with no clock edge
        wr(3'd1, 16'h0000);
        wr(3'd2, 16'h0000);
        wr(3'd4, 16'h0002);
        @(posedge clk); #0.5;
        pad_in = 16'h0000;
        #0.5;
        check("R9 wake low", {15'h0, wake}, 16'h0);
        pad_in = 16'h0002;
        #0.5;
        check("R9 wake async high", {15'h0, wake}, 16'h1);
        pad_in = 16'h0001;
        #0.5;
        check("R9 disabled line no wake", {15'h0, wake}, 16'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule